// File: doc/BRIEF.md
# Pixel Clock PLL Parameter Search

This block turns a requested pixel clock, given in hertz, into the three byte-wide settings a frequency-synthesizing PLL needs: a feedback divider code, a reference divider code and a post-divider/loop-mode byte. The reference oscillator is fixed at 14,318,180 Hz. After a start pulse the engine checks that the request is within the supported band. It then doubles the request until it lands in the oscillator's working range, recording each doubling in the post-divider byte. Finally it walks every allowed reference divider, one per clock, and keeps the divider pair whose synthesized frequency is closest to the scaled request.

The feedback value is derived incrementally, so no multiplier or divider sits in the per-step path. When the ideal feedback value is too large for a direct setting, the candidate is scored as a quartered feedback value with the loop divide-by-4 mode selected. The caller pulses `start` with `targetHz` valid and waits for `done`. The result codes then stay put until the next accepted start.

Top module: `pll_param_search`

## Requirements
- R1: After reset, busy, done and rangeErr are 0 and mCode, nCode and divCode are all 0.
- R2: A request above 220,000,000 Hz or below 3,125,000 Hz is rejected without searching. In the cycle after the start, done is 1, rangeErr is 1, busy is 0 and all three codes are 0. Both band edges are accepted.
- R3: Starting from a post-divider value of 0, while the scaled target is below 100,000,000 Hz it is doubled and 0x10 is added to divCode. divCode[7:4] therefore counts the doublings.
- R4: For every N from 3 to 257 inclusive, M is the integer part of N·F/14,318,180, where F is the scaled target. When 3 ≤ M ≤ 257, the candidate's error is |F·N − 14,318,180·M|.
- R5: When M lies outside 3..257 but M ≤ 1028, the error is computed with M's two low bits cleared. A candidate with M > 1028 is skipped.
- R6: A candidate replaces the current best only when its error is strictly smaller, so on a tie the smaller N wins.
- R7: If the winning M exceeds 257, mCode is (M>>2)−2 and divCode bit 2 is 0. Otherwise mCode is M−2 and divCode bit 2 is 1. nCode is N−2. divCode bits 3, 1 and 0 are always 0.
- R8: busy is 1 from the cycle after an accepted start until done. done is a one-cycle pulse. While busy, start is ignored. The codes and rangeErr hold their values between results.
- R9: A start given in the same cycle as done is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled when idle |
| targetHz | input | 32 | Requested pixel clock in Hz, valid with start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| rangeErr | output | 1 | Last request was outside the supported band |
| mCode | output | 8 | Feedback divider setting minus 2 |
| nCode | output | 8 | Reference divider setting minus 2 |
| divCode | output | 8 | Post-divider count in bits 7:4, loop divide-by-1 in bit 2 |

## Verification
The result strobe and a new request can coincide: the cycle that raises `done` is also an idle cycle in which `start` is sampled. The bench provokes this by raising `start` with a fresh target on exactly the sample where `done` is first seen high. It then requires `busy` one cycle later and a second result that matches its own model for the new target. A start that arrives mid-search is also tested, with an out-of-band target, and must leave both the first result and `rangeErr` untouched.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  // Strobes from the sequencer to the datapath, at most one high per cycle.
  typedef struct packed {
    logic load;        // accept an in-band request
    logic reject;      // out-of-band request, publish the error
    logic scaleStep;   // double the target once
    logic divStep;     // subtract the reference once (integer ratio)
    logic searchStep;  // evaluate the current N and advance
    logic finish;      // encode the winner into the output bytes
  } pllStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCALE,
    ST_DIVIDE,
    ST_SEARCH,
    ST_FINISH
  } pllState_t;

endpackage

// File: rtl/pll_search_ctrl.sv
module pll_search_ctrl
  import pll_search_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        inRange,
  input  logic        scaled,
  input  logic        divDone,
  input  logic        lastN,
  output pllStrobes_t stb,
  output logic        busy,
  output logic        done
);

  pllState_t state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (inRange) begin
            stb.load  = 1'b1;
            stateNext = ST_SCALE;
          end else begin
            stb.reject = 1'b1;
          end
        end
      end
      ST_SCALE: begin
        if (scaled) stateNext = ST_DIVIDE;
        else        stb.scaleStep = 1'b1;
      end
      ST_DIVIDE: begin
        if (divDone) stateNext = ST_SEARCH;
        else         stb.divStep = 1'b1;
      end
      ST_SEARCH: begin
        stb.searchStep = 1'b1;
        if (lastN) stateNext = ST_FINISH;
      end
      ST_FINISH: begin
        stb.finish = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= stb.finish | stb.reject;
    end
  end

  assign busy = (state != ST_IDLE);

  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);  // R8

  AST_REJECT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.reject |=> (!busy && done));  // R2

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.finish) |=> busy);  // R8

endmodule

// File: rtl/pll_search_dp.sv
module pll_search_dp
  import pll_search_pkg::*;
#(
  parameter int FW           = 32,
  parameter int CW           = 8,
  parameter int REF_HZ       = 14318180,
  parameter int MAX_HZ       = 220000000,
  parameter int MIN_HZ       = 3125000,
  parameter int VCO_LOW_HZ   = 100000000,
  parameter int N_FIRST      = 3,
  parameter int N_LAST       = 257,
  parameter int M_DIRECT_MIN = 3,
  parameter int M_DIRECT_MAX = 257,
  parameter int M_QUAD_MAX   = 1028,
  parameter int DIV_STEP     = 16,
  parameter int LOOP1_BIT    = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  pllStrobes_t   stb,
  input  logic [FW-1:0] targetHz,
  output logic          inRange,
  output logic          scaled,
  output logic          divDone,
  output logic          lastN,
  output logic [CW-1:0] mCode,
  output logic [CW-1:0] nCode,
  output logic [CW-1:0] divCode,
  output logic          rangeErr
);

  localparam int NW = $clog2(N_LAST + 1);
  localparam int RW = $clog2(MAX_HZ / REF_HZ + 2);
  localparam int MW = $clog2((N_LAST + 1) * (MAX_HZ / REF_HZ + 1));
  localparam int EW = FW + 2;
  localparam logic [FW-1:0] REF_F  = FW'(REF_HZ);
  localparam logic [FW:0]   REF_FX = (FW + 1)'(REF_HZ);

  // rem holds the scaled target until the divide phase, then F mod Fref.
  logic [FW-1:0] rem;
  logic [RW-1:0] ratio;
  logic [CW-1:0] divAcc;
  logic [NW-1:0] n;
  logic [MW-1:0] m;
  logic [FW-1:0] acc;     // (n * F) mod Fref
  logic [EW-1:0] bestErr;
  logic [MW-1:0] bestM;
  logic [NW-1:0] bestN;

  assign inRange = (targetHz <= FW'(MAX_HZ)) && (targetHz >= FW'(MIN_HZ));
  assign scaled  = (rem >= FW'(VCO_LOW_HZ));
  assign divDone = (rem < REF_F);
  assign lastN   = (n == NW'(N_LAST));

  // Incremental step to N+1: add the fractional part, carry into M.
  logic [FW:0]   accSum;
  logic          carry;
  logic [FW-1:0] accNext;
  logic [MW-1:0] mNext;

  always_comb begin
    accSum  = {1'b0, acc} + {1'b0, rem};
    carry   = (accSum >= REF_FX);
    accNext = carry ? FW'(accSum - REF_FX) : accSum[FW-1:0];
    mNext   = m + MW'(ratio) + MW'(carry);
  end

  // Score the current (n, m).  Fref*m = n*F - acc, so the direct error is acc.
  logic          mDirect, mQuad, evalOn, better;
  logic [EW-1:0] candErr;

  always_comb begin
    mDirect = (m >= MW'(M_DIRECT_MIN)) && (m <= MW'(M_DIRECT_MAX));
    mQuad   = !mDirect && (m <= MW'(M_QUAD_MAX));
    candErr = mQuad ? (EW'(acc) + EW'(REF_HZ) * EW'(m[1:0])) : EW'(acc);
    evalOn  = (n >= NW'(N_FIRST)) && (mDirect || mQuad);
    better  = evalOn && (candErr < bestErr);
  end

  logic          winQuad;
  logic [MW-1:0] mFinal;

  always_comb begin
    winQuad = (bestM > MW'(M_DIRECT_MAX));
    mFinal  = winQuad ? (bestM >> 2) : bestM;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem      <= '0;
      ratio    <= '0;
      divAcc   <= '0;
      n        <= '0;
      m        <= '0;
      acc      <= '0;
      bestErr  <= '1;
      bestM    <= '0;
      bestN    <= '0;
      mCode    <= '0;
      nCode    <= '0;
      divCode  <= '0;
      rangeErr <= 1'b0;
    end else begin
      if (stb.load) begin
        rem      <= targetHz;
        ratio    <= '0;
        divAcc   <= '0;
        n        <= '0;
        m        <= '0;
        acc      <= '0;
        bestErr  <= '1;
        bestM    <= '0;
        bestN    <= '0;
        rangeErr <= 1'b0;
      end
      if (stb.reject) begin
        rangeErr <= 1'b1;
        mCode    <= '0;
        nCode    <= '0;
        divCode  <= '0;
      end
      if (stb.scaleStep) begin
        rem    <= {rem[FW-2:0], 1'b0};
        divAcc <= divAcc + CW'(DIV_STEP);
      end
      if (stb.divStep) begin
        rem   <= rem - REF_F;
        ratio <= ratio + RW'(1);
      end
      if (stb.searchStep) begin
        if (better) begin
          bestErr <= candErr;
          bestM   <= m;
          bestN   <= n;
        end
        if (!lastN) begin
          n   <= n + NW'(1);
          m   <= mNext;
          acc <= accNext;
        end
      end
      if (stb.finish) begin
        mCode   <= CW'(mFinal - MW'(2));
        nCode   <= CW'(bestN - NW'(2));
        divCode <= divAcc | (winQuad ? CW'(0) : CW'(1 << LOOP1_BIT));
      end
    end
  end

  AST_N_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stb.searchStep |-> (n <= NW'(N_LAST)));  // R4

  AST_ACC_BELOW_REF: assert property (@(posedge clk) disable iff (!rstN)
    stb.searchStep |-> (acc < REF_F));  // R4

  AST_SCALED_BEFORE_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    stb.divStep |-> (ratio != '0 || rem >= FW'(VCO_LOW_HZ)));  // R3

  AST_ERR_ZERO_CODES: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |-> (mCode == '0 && nCode == '0 && divCode == '0));  // R2

  AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> (divCode[3] == 1'b0 && divCode[1:0] == 2'b00));  // R7

  AST_CODES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.finish || stb.reject || stb.load) |=>
      ($stable(mCode) && $stable(nCode) && $stable(divCode) && $stable(rangeErr)));  // R8

endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
  import pll_search_pkg::*;
#(
  parameter int FW         = 32,
  parameter int CW         = 8,
  parameter int REF_HZ     = 14318180,
  parameter int MAX_HZ     = 220000000,
  parameter int MIN_HZ     = 3125000,
  parameter int VCO_LOW_HZ = 100000000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [FW-1:0] targetHz,
  output logic          busy,
  output logic          done,
  output logic          rangeErr,
  output logic [CW-1:0] mCode,
  output logic [CW-1:0] nCode,
  output logic [CW-1:0] divCode
);

  pllStrobes_t stb;
  logic inRange, scaled, divDone, lastN;

  pll_search_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .inRange (inRange),
    .scaled  (scaled),
    .divDone (divDone),
    .lastN   (lastN),
    .stb     (stb),
    .busy    (busy),
    .done    (done)
  );

  pll_search_dp #(
    .FW         (FW),
    .CW         (CW),
    .REF_HZ     (REF_HZ),
    .MAX_HZ     (MAX_HZ),
    .MIN_HZ     (MIN_HZ),
    .VCO_LOW_HZ (VCO_LOW_HZ)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .targetHz (targetHz),
    .inRange  (inRange),
    .scaled   (scaled),
    .divDone  (divDone),
    .lastN    (lastN),
    .mCode    (mCode),
    .nCode    (nCode),
    .divCode  (divCode),
    .rangeErr (rangeErr)
  );

endmodule

// File: tb/test_pll_param_search.sv
`timescale 1ns/1ps
module test_pll_param_search;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] targetHz = '0;
  logic        busy, done, rangeErr;
  logic [7:0]  mCode, nCode, divCode;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pll_param_search i_pll_param_search (
    .clk(clk), .rstN(rstN), .start(start), .targetHz(targetHz),
    .busy(busy), .done(done), .rangeErr(rangeErr),
    .mCode(mCode), .nCode(nCode), .divCode(divCode)
  );

  localparam longint unsigned FREF = 64'd14318180;
  localparam int NVEC = 14;
  localparam logic [31:0] VEC_HZ [NVEC] = '{
    32'd25175000, 32'd3125000, 32'd220000000, 32'd3124999, 32'd220000001,
    32'd100000000, 32'd99999999, 32'd65000000, 32'd40000000, 32'd14318180,
    32'd108000000, 32'd157500000, 32'd143181800, 32'd0 };
  localparam logic VEC_ERR [NVEC] = '{
    1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b1 };

  // Model from the requirements: direct products, no incremental tricks.
  function automatic logic [23:0] refCodes(input logic [31:0] hz);
    longint unsigned f = longint'(hz);
    longint unsigned bestErr = 64'hFFFF_FFFF_FFFF_FFFF;
    longint unsigned bm = 0, bn = 0, mo;
    logic [7:0] dv = 8'h00;
    while (f < 64'd100000000) begin
      f  = f << 1;
      dv = dv + 8'h10;
    end
    for (int nn = 3; nn <= 257; nn++) begin
      longint unsigned mm = (f * longint'(nn)) / FREF;
      longint unsigned e;
      if (mm >= 3 && mm <= 257) begin
        e = f * longint'(nn) - FREF * mm;
        if (e < bestErr) begin bestErr = e; bm = mm; bn = longint'(nn); end
      end else if (mm <= 1028) begin
        e = f * longint'(nn) - FREF * (mm & ~64'd3);
        if (e < bestErr) begin bestErr = e; bm = mm; bn = longint'(nn); end
      end
    end
    if (bm > 257) mo = bm >> 2;
    else begin mo = bm; dv = dv | 8'h04; end
    return {8'(mo - 2), 8'(bn - 2), dv};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart(input logic [31:0] hz);
    @(negedge clk);
    start = 1'b1;
    targetHz = hz;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int cnt = 0;
    while (!done && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
    check(done, "R8", "done timeout", 32'(done), 32'd1);
  endtask

  task automatic checkResult(input logic [31:0] hz, input logic expErr, input string req);
    logic [23:0] e;
    if (expErr) begin
      check(rangeErr == 1'b1 && {mCode, nCode, divCode} == 24'h0 && !busy,
            "R2", "reject", {7'd0, rangeErr, mCode, nCode, divCode}, 32'h0100_0000);
    end else begin
      e = refCodes(hz);
      check(rangeErr == 1'b0 && {mCode, nCode, divCode} == e,
            req, "codes", {7'd0, rangeErr, mCode, nCode, divCode}, {8'd0, e});
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nFails++;
      $display("FAIL R8 watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    check({busy, done, rangeErr, mCode, nCode, divCode} == 27'd0, "R1", "reset outputs",
          {5'd0, busy, done, rangeErr, mCode, nCode, divCode}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, rangeErr} == 3'd0, "R1", "idle after reset",
          {29'd0, busy, done, rangeErr}, 32'd0);

    // Vector table: R2 band, R3 scaling, R4 R5 search, R6 ties, R7 encoding
    for (int i = 0; i < NVEC; i++) begin
      pulseStart(VEC_HZ[i]);
      if (!VEC_ERR[i])
        check(busy == 1'b1, "R8", "busy after start", 32'(busy), 32'd1);
      waitDone();
      checkResult(VEC_HZ[i], VEC_ERR[i], "R4 R5 R7");
      @(negedge clk);
      check(done == 1'b0, "R8", "done one cycle", 32'(done), 32'd0);
    end

    // R6: exact multiple of the reference; N=3 and N=6 tie at zero error
    pulseStart(32'd143181800);
    waitDone();
    check({mCode, nCode, divCode} == 24'h1C_01_04, "R6", "tie keeps smaller N",
          {8'd0, mCode, nCode, divCode}, 32'h001C_0104);

    // R3: lower band edge needs five doublings
    pulseStart(32'd3125000);
    waitDone();
    check(divCode[7:4] == 4'd5, "R3", "doubling count", 32'(divCode[7:4]), 32'd5);

    // R7: exact 7x reference gives M=21, N=3 in the direct branch
    pulseStart(32'd100227260);
    waitDone();
    check({mCode, nCode, divCode} == 24'h13_01_04, "R7", "direct encode",
          {8'd0, mCode, nCode, divCode}, 32'h0013_0104);
    held = {mCode, nCode, divCode};
    repeat (5) @(negedge clk);
    check({mCode, nCode, divCode} == held, "R8", "codes hold idle",
          {8'd0, mCode, nCode, divCode}, {8'd0, held});

    // R8: a start during the search is ignored, even an out-of-band one
    pulseStart(32'd65000000);
    repeat (10) @(negedge clk);
    pulseStart(32'd5);
    waitDone();
    checkResult(32'd65000000, 1'b0, "R8");

    // R9: start raised in the very cycle done is high
    pulseStart(32'd40000000);
    waitDone();
    start = 1'b1;
    targetHz = 32'd108000000;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9", "start on done accepted", 32'(busy), 32'd1);
    waitDone();
    checkResult(32'd108000000, 1'b0, "R9");

    // R2 then a good request clears the flag
    pulseStart(32'd250000000);
    waitDone();
    checkResult(32'd250000000, 1'b1, "R2");
    pulseStart(32'd25175000);
    waitDone();
    checkResult(32'd25175000, 1'b0, "R2");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule